// File: doc/BRIEF.md
# Pointer-Indirect Word Copy Engine

The engine moves a run of 32-bit words from a source region to a destination region, where either side can be a memory buffer or a fixed I/O port address. The command does not carry the copy addresses. It carries two addresses that each hold a pointer: one pointer gives where the data comes from, the other gives where it goes. The engine reads both pointers from memory first. It then repeats a read of one word at the source followed by a write of that word at the destination, once for each word in the count.

A two-bit mode picks the address rule for each side. A side that is a buffer advances by one word (4 bytes) after every write. A side that is a port keeps the same address. Every memory access holds a request until the memory gives an acknowledge or an error. An error stops the command at once. Completion is a single-cycle done pulse, and an error flag is high in that same cycle when the command was aborted.

Top module: `wcopy_engine`

## Requirements
- R1: A start pulse seen while idle begins with a read at the source-pointer address and then a read at the destination-pointer address. The two words returned become the initial source and destination addresses.
- R2: Each access keeps mem_req high, and keeps mem_addr, mem_we and mem_wdata unchanged, until a cycle in which mem_ack or mem_err is high. Only that cycle ends the access.
- R3: For each word, a read (mem_we=0) at the current source address is followed by a write (mem_we=1) at the current destination address. The write carries the data that the read returned on its acknowledge.
- R4: Mode 2'b00: after each write both addresses advance by 4.
- R5: Mode 2'b01: the source address stays fixed and the destination address advances by 4.
- R6: Mode 2'b10: the source address advances by 4 and the destination address stays fixed.
- R7: Mode 2'b11: both addresses stay fixed for the whole command.
- R8: A count of N>0 gives exactly N read/write pairs. done is high for exactly one cycle, in the cycle after the last write is acknowledged, and err is low in that cycle.
- R9: A count of zero gives no data access. done is high in the cycle after the destination-pointer read is acknowledged.
- R10: mem_err on any access ends the command with no further request. done and err are both high in the next cycle.
- R11: A start pulse while a command is in progress is ignored. The running command's accesses and completion are unchanged, and no new command follows.
- R12: During and right after reset, mem_req, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start pulse, accepted only when idle |
| cmd_src_ptr_addr | input | 32 | Address of the word holding the source address |
| cmd_dst_ptr_addr | input | 32 | Address of the word holding the destination address |
| cmd_mode | input | 2 | Address rule: 00 both step, 01 source fixed, 10 destination fixed, 11 both fixed |
| cmd_count | input | 16 | Number of words to copy |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | High together with done when the command was aborted |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Access byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the acknowledge cycle |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed |

## Verification
The assertions assume that the memory never raises mem_ack or mem_err while mem_req is low. They also assume that mem_rdata matters only in the cycle of a read acknowledge, and that a start pulse lasts one cycle. The bench memory answers only a pending request, after a varying wait of zero to two cycles. It drives junk on mem_rdata outside acknowledge cycles, so a capture at the wrong cycle would be seen. Commands are started with single-cycle pulses. The extra pulse that exercises R11 is sent only while a command is already running.

// File: rtl/wcopy_pkg.sv
// Shared types for the word copy engine.
// Assumes: mode bit 0 set means the source side is a fixed port,
//          mode bit 1 set means the destination side is a fixed port.
package wcopy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_SRC,
        ST_FETCH_DST,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } wc_state_t;

    typedef enum logic [1:0] {
        MODE_BOTH_STEP  = 2'b00,
        MODE_SRC_FIXED  = 2'b01,
        MODE_DST_FIXED  = 2'b10,
        MODE_BOTH_FIXED = 2'b11
    } wc_mode_t;

    // True when the source address advances after each word.
    function automatic logic src_steps(input wc_mode_t m);
        return !m[0];
    endfunction

    // True when the destination address advances after each word.
    function automatic logic dst_steps(input wc_mode_t m);
        return !m[1];
    endfunction

    // True for any state that drives a memory request.
    function automatic logic is_access(input wc_state_t s);
        return (s == ST_FETCH_SRC) || (s == ST_FETCH_DST) ||
               (s == ST_READ) || (s == ST_WRITE);
    endfunction

endpackage

// File: rtl/wcopy_fsm.sv
// Sequencer for the copy engine.
// Walks idle -> source pointer fetch -> destination pointer fetch ->
// (read -> write)* -> done -> idle. An access state leaves only on a
// good acknowledge or on an error; an error always goes to done.
// Assumes: acc_ok and acc_err are never high together.
module wcopy_fsm
    import wcopy_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      acc_ok,
    input  logic      acc_err,
    input  logic      count_zero,
    input  logic      last_word,
    output wc_state_t state
);

    wc_state_t state_nx;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start) state_nx = ST_FETCH_SRC;
            ST_FETCH_SRC: begin
                if (acc_err)     state_nx = ST_DONE;
                else if (acc_ok) state_nx = ST_FETCH_DST;
            end
            ST_FETCH_DST: begin
                if (acc_err)     state_nx = ST_DONE;
                else if (acc_ok) state_nx = count_zero ? ST_DONE : ST_READ;
            end
            ST_READ: begin
                if (acc_err)     state_nx = ST_DONE;
                else if (acc_ok) state_nx = ST_WRITE;
            end
            ST_WRITE: begin
                if (acc_err)     state_nx = ST_DONE;
                else if (acc_ok) state_nx = last_word ? ST_DONE : ST_READ;
            end
            ST_DONE:      state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assert_done_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE));

    assert_abort_on_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_access(state) && acc_err) |=> (state == ST_DONE));

    assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_FETCH_DST) && acc_ok && count_zero) |=> (state == ST_DONE));

    assert_wait_for_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_access(state) && !acc_ok && !acc_err) |=> $stable(state));

endmodule

// File: rtl/wcopy_addr_reg.sv
// One side's copy address. Loaded from a fetched pointer; after each
// word it advances by STEP bytes when its side steps, or holds when the
// side is a fixed port.
// Assumes: load and advance are never high together.
module wcopy_addr_reg #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          advance,
    input  logic          step_en,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    // Address register: load, step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                  addr <= '0;
        else if (load)               addr <= load_val;
        else if (advance && step_en) addr <= addr + STEP_V;
    end

    assert_fixed_side_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !step_en && !load) |=> $stable(addr));

    assert_no_load_and_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && advance));

endmodule

// File: rtl/wcopy_word_counter.sv
// Remaining-word counter. Loaded with the command count, decremented
// after each acknowledged write. Flags zero and the last word.
// Assumes: dec is raised only while words remain.
module wcopy_word_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          is_zero,
    output logic          is_last
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] remain;

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)    remain <= '0;
        else if (load) remain <= load_val;
        else if (dec)  remain <= remain - ONE;
    end

    // Status flags for the sequencer.
    always_comb begin
        is_zero = (remain == '0);
        is_last = (remain == ONE);
    end

    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !is_zero);

endmodule

// File: rtl/wcopy_engine.sv
// Pointer-indirect word copy engine, top level.
// Captures a command while idle, fetches the two pointers, then copies
// words one read and one write at a time through a single request /
// acknowledge master port. The address of each side steps by one word or
// stays fixed according to the mode. An error response aborts the command.
// Assumes: mem_ack / mem_err are raised only while mem_req is high.
module wcopy_engine
    import wcopy_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic [AW-1:0] cmd_src_ptr_addr,
    input  logic [AW-1:0] cmd_dst_ptr_addr,
    input  logic [1:0]    cmd_mode,
    input  logic [CW-1:0] cmd_count,
    output logic          done,
    output logic          err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err
);

    localparam int WORD_BYTES = DW / 8;
    localparam int NSIDE      = 2;   // 0 = source, 1 = destination

    wc_state_t     state;
    wc_mode_t      mode_q;
    logic [AW-1:0] src_pa_q;
    logic [AW-1:0] dst_pa_q;
    logic [DW-1:0] data_q;
    logic          err_q;
    logic          accept;
    logic          acc_ok;
    logic          acc_err;
    logic          count_zero;
    logic          last_word;
    logic          word_done;
    logic [AW-1:0] side_addr [NSIDE];

    // Handshake qualifiers.
    always_comb begin
        accept    = (state == ST_IDLE) && cmd_start;
        acc_ok    = mem_req && mem_ack && !mem_err;
        acc_err   = mem_req && mem_err;
        word_done = (state == ST_WRITE) && acc_ok;
    end

    // Command capture, taken only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_BOTH_STEP;
            src_pa_q <= '0;
            dst_pa_q <= '0;
        end else if (accept) begin
            mode_q   <= wc_mode_t'(cmd_mode);
            src_pa_q <= cmd_src_ptr_addr;
            dst_pa_q <= cmd_dst_ptr_addr;
        end
    end

    // Read data holding register, captured on a read acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                           data_q <= '0;
        else if ((state == ST_READ) && acc_ok) data_q <= mem_rdata;
    end

    // Sticky abort flag, cleared when a new command is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (accept)  err_q <= 1'b0;
        else if (acc_err) err_q <= 1'b1;
    end

    wcopy_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .acc_ok     (acc_ok),
        .acc_err    (acc_err),
        .count_zero (count_zero),
        .last_word  (last_word),
        .state      (state)
    );

    wcopy_word_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cmd_count),
        .dec      (word_done),
        .is_zero  (count_zero),
        .is_last  (last_word)
    );

    // One address register per side; the mode picks each side's rule.
    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        localparam wc_state_t FETCH_ST = (g == 0) ? ST_FETCH_SRC : ST_FETCH_DST;
        logic step_en;
        logic load;

        // Side-specific load strobe and step enable.
        always_comb begin
            load    = (state == FETCH_ST) && acc_ok;
            step_en = (g == 0) ? src_steps(mode_q) : dst_steps(mode_q);
        end

        wcopy_addr_reg #(.AW(AW), .STEP(WORD_BYTES)) u_addr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .load_val (mem_rdata[AW-1:0]),
            .advance  (word_done),
            .step_en  (step_en),
            .addr     (side_addr[g])
        );
    end

    // Master port drive from the current state.
    always_comb begin
        mem_req   = is_access(state);
        mem_we    = (state == ST_WRITE);
        mem_wdata = data_q;
        unique case (state)
            ST_FETCH_SRC: mem_addr = src_pa_q;
            ST_FETCH_DST: mem_addr = dst_pa_q;
            ST_READ:      mem_addr = side_addr[0];
            ST_WRITE:     mem_addr = side_addr[1];
            default:      mem_addr = '0;
        endcase
    end

    // Completion outputs.
    always_comb begin
        done = (state == ST_DONE);
        err  = done && err_q;
    end

    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_err_only_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && (state != ST_IDLE)) |=>
            ($stable(src_pa_q) && $stable(dst_pa_q) && $stable(mode_q)));

    assert_no_req_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

endmodule

// File: tb/tb_wcopy_engine.sv
// Bench for the word copy engine: a behavioural memory with varying
// latency and a queue-based reference of the expected access stream,
// compared on every falling clock edge.
module tb_wcopy_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [31:0] cmd_src_ptr_addr = '0;
    logic [31:0] cmd_dst_ptr_addr = '0;
    logic [1:0]  cmd_mode = '0;
    logic [15:0] cmd_count = '0;
    logic        done, err, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;

    always #2.5 clk = ~clk;

    wcopy_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start),
        .cmd_src_ptr_addr(cmd_src_ptr_addr), .cmd_dst_ptr_addr(cmd_dst_ptr_addr),
        .cmd_mode(cmd_mode), .cmd_count(cmd_count), .done(done), .err(err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err)
    );

    typedef struct packed { logic we; logic [31:0] addr; } acc_t;

    int          n_checks = 0;
    int          n_fails  = 0;
    int          cyc      = 0;
    logic [31:0] mem [logic [31:0]];
    acc_t        exp_q [$];
    string       cur_tag = "R12";
    int          err_at  = -1;
    int          acc_idx = 0;
    int          wait_left = -1;
    logic [31:0] last_rd = '0;
    bit          done_due = 0;
    bit          err_due  = 0;
    bit          model_on = 0;

    function automatic logic [31:0] mrd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return {a[15:0], 16'hC0DE} ^ 32'h1357_0000;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            finish_run();
        end
    end

    // Reference model and memory responder.
    always @(negedge clk) begin
        if (model_on) begin
            bit   due_n;
            acc_t h;
            due_n = 0;
            chk(done == done_due, done_due ? cur_tag : "R8", "done",
                32'(done), 32'(done_due));
            chk(err == (done_due && err_due), "R10", "err",
                32'(err), 32'(done_due && err_due));
            mem_ack   = 1'b0;
            mem_err   = 1'b0;
            mem_rdata = 32'hBAD0_0000 | 32'(acc_idx);
            if (mem_req) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected request", mem_addr, 32'h0);
                end else begin
                    h = exp_q[0];
                    chk(mem_addr == h.addr, (acc_idx < 2) ? "R1" : cur_tag,
                        "address", mem_addr, h.addr);
                    chk(mem_we == h.we, "R3", "direction", 32'(mem_we), 32'(h.we));
                    if (h.we) chk(mem_wdata == last_rd, "R3", "write data",
                                  mem_wdata, last_rd);
                    if (wait_left < 0) wait_left = int'($urandom % 3);
                    if (wait_left == 0) begin
                        if (acc_idx == err_at) begin
                            mem_err = 1'b1;
                            exp_q.delete();
                            due_n   = 1;
                            err_due = 1;
                        end else begin
                            mem_ack = 1'b1;
                            if (!h.we) begin
                                mem_rdata = mrd(h.addr);
                                last_rd   = mem_rdata;
                            end else begin
                                mem[h.addr] = mem_wdata;
                            end
                            void'(exp_q.pop_front());
                            if (exp_q.size() == 0) begin
                                due_n   = 1;
                                err_due = 0;
                            end
                        end
                        acc_idx++;
                        wait_left = -1;
                    end else begin
                        wait_left--;
                    end
                end
            end
            done_due = due_n;
        end
    end

    // Build the expected accesses, issue one command and wait for it to end.
    task automatic run_cmd(input logic [31:0] spa, input logic [31:0] dpa,
                           input logic [1:0] mode, input int cnt, input int eat,
                           input string tag, input bit poke);
        logic [31:0] s, d;
        int          t;
        exp_q.delete();
        exp_q.push_back('{we: 1'b0, addr: spa});
        exp_q.push_back('{we: 1'b0, addr: dpa});
        s = mrd(spa);
        d = mrd(dpa);
        for (int i = 0; i < cnt; i++) begin
            exp_q.push_back('{we: 1'b0, addr: s});
            exp_q.push_back('{we: 1'b1, addr: d});
            if (!mode[0]) s += 32'd4;
            if (!mode[1]) d += 32'd4;
        end
        cur_tag = tag;
        err_at  = eat;
        acc_idx = 0;
        @(negedge clk);
        cmd_start = 1'b1; cmd_src_ptr_addr = spa; cmd_dst_ptr_addr = dpa;
        cmd_mode = mode; cmd_count = 16'(cnt);
        @(negedge clk);
        cmd_start = 1'b0;
        cmd_src_ptr_addr = 32'hFFFF_0000; cmd_dst_ptr_addr = 32'hEEEE_0000;
        if (poke) begin
            repeat (3) @(negedge clk);
            cmd_start = 1'b1; cmd_mode = 2'b11; cmd_count = 16'd9;
            @(negedge clk);
            cmd_start = 1'b0;
        end
        t = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 3000, tag, "command completion", 32'(t), 32'd3000);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        mem[32'h0000_0100] = 32'h0000_1000;
        mem[32'h0000_0104] = 32'h0000_2000;
        mem[32'h0000_0108] = 32'h0000_3000;
        mem[32'h0000_010C] = 32'h0000_4000;
        mem[32'h0000_1000] = 32'hFEED_0001;
        mem[32'h0000_1004] = 32'hFEED_0002;
        repeat (3) @(negedge clk);
        chk(mem_req == 1'b0, "R12", "req in reset", 32'(mem_req), 32'h0);
        chk(done == 1'b0, "R12", "done in reset", 32'(done), 32'h0);
        chk(err == 1'b0, "R12", "err in reset", 32'(err), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req == 1'b0, "R12", "req after reset", 32'(mem_req), 32'h0);
        model_on = 1;

        run_cmd(32'h100, 32'h104, 2'b00, 4, -1, "R4", 0);
        run_cmd(32'h108, 32'h10C, 2'b01, 3, -1, "R5", 0);
        run_cmd(32'h100, 32'h10C, 2'b10, 3, -1, "R6", 0);
        run_cmd(32'h108, 32'h104, 2'b11, 2, -1, "R7", 0);
        run_cmd(32'h100, 32'h104, 2'b00, 1, -1, "R8", 0);
        run_cmd(32'h100, 32'h104, 2'b00, 0, -1, "R9", 0);
        run_cmd(32'h100, 32'h104, 2'b00, 3,  0, "R10", 0);
        run_cmd(32'h100, 32'h104, 2'b00, 3,  1, "R10", 0);
        run_cmd(32'h100, 32'h104, 2'b10, 3,  5, "R10", 0);
        run_cmd(32'h100, 32'h104, 2'b01, 3,  4, "R10", 0);
        run_cmd(32'h108, 32'h104, 2'b00, 5, -1, "R11", 1);
        run_cmd(32'h100, 32'h10C, 2'b00, 2, -1, "R8", 0);
        chk(exp_q.size() == 0, "R8", "leftover accesses", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

endmodule